// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital front end of a two-channel digital-to-analog converter. A host drives a three-wire serial port (active-low chip select, serial clock, data in) and sends 16-bit command words. Each word carries a two-bit destination code, a speed flag, a power-down flag and a 12-bit code. The block presents the two channel codes and the two flags in parallel to the analog section.

Channel B can be loaded in two ways. A direct write sets it at once. A staged write parks a value in a holding buffer, and the next channel A write copies that buffer into channel B on the same edge. This lets both outputs change together. The whole block runs on the serial clock. An asynchronous power-on reset clears every register.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While power-on reset is asserted, and after its release until the first command, both channel codes, the holding buffer, the speed flag and the power-down flag are zero (slow mode, normal operation).
- R2: While chip select is low, one data bit is taken on each falling serial clock edge, most significant bit first. In the 16-bit word, bit 15 is the upper destination bit, bit 14 the speed flag, bit 13 the power-down flag, bit 12 the lower destination bit, and bits 11..0 the code.
- R3: Destination 00 (bit15=0, bit12=0) writes the code into both the channel B latch and the holding buffer.
- R4: Destination 01 (bit15=0, bit12=1) writes the code into the holding buffer only. Both channel latches keep their values.
- R5: Destination 10 (bit15=1, bit12=0) writes the code into channel A. On the same edge it copies the holding buffer into channel B.
- R6: Destination 11 leaves both channel latches and the holding buffer unchanged.
- R7: Every committed word, including a reserved one, loads the speed flag (1 = fast) and the power-down flag (1 = powered down) from its bits 14 and 13.
- R8: A complete word takes effect on the first rising serial clock edge after its 16th falling edge, and not before.
- R9: If chip select rises after 1 to 15 bits, the received bits are committed as a word. They sit right-aligned, with the upper bits zero. The commit happens on the rising edge after the first falling edge that sees chip select high.
- R10: After 16 bits, further clock edges with chip select still low are ignored. A new word is accepted only after chip select has gone high and then low again.
- R11: A frame in which chip select rises with no bit received changes nothing.
- R12: A word sent as two 8-bit transfers, with chip select held low and the clock paused between them, acts the same as one 16-bit transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; data taken on falling edges, registers updated on rising edges |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low, frames a command |
| din | input | 1 | Serial data, MSB first |
| ch_a_code | output | 12 | Channel A output latch |
| ch_b_code | output | 12 | Channel B output latch |
| fast_mode | output | 1 | Speed flag, 1 = fast settling |
| power_down | output | 1 | Power-down flag, 1 = powered down |

## Verification
Two functions fall on the same rising edge in the synchronous update command: channel A takes the new code while channel B takes the holding buffer. On that edge the flags are also reloaded. The bench first stages a buffer value with a buffer-only write, then sends a channel A write. It checks that both channels hold their new values after one and the same edge, and that channel B received the staged value rather than the word's code. A reserved word placed between staging and update confirms that the buffer survived, because the later synchronous update still delivers the staged value.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  typedef enum logic [1:0] {
    DST_B_AND_BUF = 2'b00,
    DST_BUF_ONLY  = 2'b01,
    DST_A_SYNC_B  = 2'b10,
    DST_RESERVED  = 2'b11
  } dst_sel_e;

endpackage

// File: rtl/dacif_rst_sync.sv
module dacif_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[s] <= 1'b0;
          else         sync_q[s] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dacif_shift_rx.sv
module dacif_shift_rx #(
  parameter int WORD_W = 16
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  output logic              xfer_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              xfer_q, xfer_d;

  // next-state: shift while selected, commit on full word or early deselect
  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    xfer_d  = 1'b0;
    if (cs_n) begin
      shreg_d = '0;
      cnt_d   = '0;
      if ((cnt_q != '0) && (cnt_q != CNT_FULL)) begin
        xfer_d = 1'b1;
        word_d = shreg_q;
      end
    end else if (cnt_q != CNT_FULL) begin
      shreg_d = {shreg_q[WORD_W-2:0], din};
      cnt_d   = cnt_q + CNT_W'(1);
      if (cnt_q == CNT_LAST) begin
        xfer_d = 1'b1;
        word_d = {shreg_q[WORD_W-2:0], din};
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      xfer_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      xfer_q  <= xfer_d;
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (xfer_d) word_q <= word_d;
  end

  assign xfer_o = xfer_q;
  assign word_o = word_q;

  p_cnt_limit_r10: assert property (@(negedge sclk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  p_hold_after_full_r10: assert property (@(negedge sclk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && !cs_n) |=> (cnt_q == CNT_FULL && !xfer_q));

  p_single_commit_r8: assert property (@(negedge sclk) disable iff (!rst_n)
    xfer_q |=> !xfer_q);

  p_empty_frame_r11: assert property (@(negedge sclk) disable iff (!rst_n)
    (cs_n && cnt_q == '0) |=> !xfer_q);

endmodule

// File: rtl/dacif_reg_bank.sv
module dacif_reg_bank
  import dacif_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                sclk,
  input  logic                rst_n,
  input  logic                xfer,
  input  logic [DATA_W+3:0]   word,
  output logic [DATA_W-1:0]   ch_a,
  output logic [DATA_W-1:0]   ch_b,
  output logic                fast,
  output logic                pwr_dn
);

  localparam int WORD_W = DATA_W + 4;
  localparam int POS_SEL_HI = WORD_W - 1;
  localparam int POS_SPEED  = WORD_W - 2;
  localparam int POS_PDOWN  = WORD_W - 3;
  localparam int POS_SEL_LO = WORD_W - 4;

  dst_sel_e          sel;
  logic [DATA_W-1:0] code;
  logic [DATA_W-1:0] a_q, b_q, buf_q;
  logic [DATA_W-1:0] b_d;
  logic              fast_q, pd_q;
  logic              a_en, b_en, buf_en;

  assign sel  = dst_sel_e'({word[POS_SEL_HI], word[POS_SEL_LO]});
  assign code = word[DATA_W-1:0];

  // load enables and channel B source
  always_comb begin
    a_en   = 1'b0;
    b_en   = 1'b0;
    buf_en = 1'b0;
    b_d    = code;
    if (xfer) begin
      unique case (sel)
        DST_B_AND_BUF: begin b_en = 1'b1; buf_en = 1'b1; end
        DST_BUF_ONLY:  buf_en = 1'b1;
        DST_A_SYNC_B:  begin a_en = 1'b1; b_en = 1'b1; b_d = buf_q; end
        DST_RESERVED:  ;
      endcase
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)    a_q <= '0;
    else if (a_en) a_q <= code;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)    b_q <= '0;
    else if (b_en) b_q <= b_d;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= code;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (xfer) begin
      fast_q <= word[POS_SPEED];
      pd_q   <= word[POS_PDOWN];
    end
  end

  assign ch_a   = a_q;
  assign ch_b   = b_q;
  assign fast   = fast_q;
  assign pwr_dn = pd_q;

  // R1: reset state
  always @(negedge sclk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (a_q == '0 && b_q == '0 && buf_q == '0 && !fast_q && !pd_q);
    end
  end

  p_b_and_buf_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    (xfer && sel == DST_B_AND_BUF) |=> (b_q == $past(code) && buf_q == $past(code)));

  p_buf_only_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    (xfer && sel == DST_BUF_ONLY) |=> ($stable(a_q) && $stable(b_q)));

  p_sync_update_r5: assert property (@(posedge sclk) disable iff (!rst_n)
    (xfer && sel == DST_A_SYNC_B) |=> (a_q == $past(code) && b_q == $past(buf_q)));

  p_reserved_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    (xfer && sel == DST_RESERVED) |=> ($stable(a_q) && $stable(b_q) && $stable(buf_q)));

  p_quiet_r8: assert property (@(posedge sclk) disable iff (!rst_n)
    !xfer |=> ($stable(a_q) && $stable(b_q) && $stable(buf_q) && $stable(fast_q) && $stable(pd_q)));

endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if #(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sclk,
  input  logic              por_n,
  input  logic              cs_n,
  input  logic              din,
  output logic [DATA_W-1:0] ch_a_code,
  output logic [DATA_W-1:0] ch_b_code,
  output logic              fast_mode,
  output logic              power_down
);

  localparam int WORD_W = DATA_W + 4;

  logic              rst_n;
  logic              xfer;
  logic [WORD_W-1:0] word;

  dacif_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (sclk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  dacif_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .sclk   (sclk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .din    (din),
    .xfer_o (xfer),
    .word_o (word)
  );

  dacif_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .sclk   (sclk),
    .rst_n  (rst_n),
    .xfer   (xfer),
    .word   (word),
    .ch_a   (ch_a_code),
    .ch_b   (ch_b_code),
    .fast   (fast_mode),
    .pwr_dn (power_down)
  );

endmodule

// File: tb/dual_dac_serial_if_tb.sv
`timescale 1ns/100ps
module dual_dac_serial_if_tb;

  logic        base_clk = 1'b0;
  logic        sclk_en  = 1'b1;
  logic        sclk;
  logic        por_n    = 1'b0;
  logic        cs_n     = 1'b1;
  logic        din      = 1'b0;
  logic [11:0] ch_a_code, ch_b_code;
  logic        fast_mode, power_down;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 base_clk = ~base_clk;
  assign sclk = base_clk & sclk_en;

  dual_dac_serial_if u_dut (
    .sclk       (sclk),
    .por_n      (por_n),
    .cs_n       (cs_n),
    .din        (din),
    .ch_a_code  (ch_a_code),
    .ch_b_code  (ch_b_code),
    .fast_mode  (fast_mode),
    .power_down (power_down)
  );

  task automatic check(input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [11:0] a, input logic [11:0] b,
                           input logic f, input logic p);
    check(req, "ch_a", ch_a_code, a);
    check(req, "ch_b", ch_b_code, b);
    check(req, "fast", {11'd0, fast_mode}, {11'd0, f});
    check(req, "pdown", {11'd0, power_down}, {11'd0, p});
  endtask

  // drive n bits of v, MSB first, one per serial clock, chip select low
  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(posedge base_clk); #1;
      cs_n = 1'b0;
      din  = v[i];
    end
  endtask

  task automatic end_frame();
    @(posedge base_clk); #1;
    cs_n = 1'b1;
    din  = 1'b0;
    @(posedge base_clk); #1;
  endtask

  task automatic send_word(input logic [15:0] w);
    shift_bits(w, 16);
    @(posedge base_clk); #1;
  endtask

  task automatic t_reset();
    repeat (4) @(posedge base_clk);
    #1 check_all("R1", 12'h000, 12'h000, 1'b0, 1'b0);
    por_n = 1'b1;
    repeat (4) @(posedge base_clk);
    #1 check_all("R1", 12'h000, 12'h000, 1'b0, 1'b0);
  endtask

  task automatic t_write_b();
    send_word(16'h4A5C);
    check_all("R3", 12'h000, 12'hA5C, 1'b1, 1'b0);
    end_frame();
  endtask

  task automatic t_buffer_only();
    send_word(16'h13C7);
    check_all("R4", 12'h000, 12'hA5C, 1'b0, 1'b0);
    end_frame();
  endtask

  task automatic t_sync_update();
    send_word(16'h8123);
    check_all("R5", 12'h123, 12'h3C7, 1'b0, 1'b0);
    end_frame();
  endtask

  task automatic t_reserved();
    send_word(16'hFEEE);
    check_all("R6", 12'h123, 12'h3C7, 1'b1, 1'b1);
    end_frame();
    send_word(16'h8456);
    check_all("R6", 12'h456, 12'h3C7, 1'b0, 1'b0);
    end_frame();
  endtask

  task automatic t_commit_edge();
    shift_bits(16'h0ABC, 16);
    #2;
    check("R8", "ch_b before rising edge", ch_b_code, 12'h3C7);
    @(posedge base_clk); #1;
    check("R8", "ch_b after rising edge", ch_b_code, 12'hABC);
    end_frame();
  endtask

  task automatic t_extra_edges();
    send_word(16'h0111);
    shift_bits(16'hFFFF, 8);
    @(posedge base_clk); #1;
    check_all("R10", 12'h456, 12'h111, 1'b0, 1'b0);
    end_frame();
    send_word(16'h0222);
    check("R10", "ch_b after re-arm", ch_b_code, 12'h222);
    end_frame();
  endtask

  task automatic t_partial();
    shift_bits(16'h0DEF, 12);
    @(posedge base_clk); #1 cs_n = 1'b1;
    @(posedge base_clk); #1;
    check_all("R9", 12'h456, 12'hDEF, 1'b0, 1'b0);
    shift_bits(16'h2555, 14);
    @(posedge base_clk); #1 cs_n = 1'b1;
    @(posedge base_clk); #1;
    check_all("R9", 12'h456, 12'h555, 1'b0, 1'b1);
  endtask

  task automatic t_empty_frame();
    @(posedge base_clk); #1 cs_n = 1'b0; din = 1'b1;
    #1 cs_n = 1'b1;
    repeat (3) @(posedge base_clk);
    #1 check_all("R11", 12'h456, 12'h555, 1'b0, 1'b1);
    din = 1'b0;
  endtask

  task automatic t_byte_pair();
    shift_bits(16'h00C7, 8);
    #2 sclk_en = 1'b0;
    repeat (10) @(posedge base_clk);
    #3 sclk_en = 1'b1;
    shift_bits(16'h00E1, 8);
    @(posedge base_clk); #1;
    check_all("R12", 12'h7E1, 12'h555, 1'b1, 1'b0);
    end_frame();
  endtask

  initial begin
    t_reset();
    t_write_b();      // R2 layout and MSB order, R3, R7
    t_buffer_only();  // R4
    t_sync_update();  // R5
    t_reserved();     // R6, R7
    t_commit_edge();  // R8
    t_extra_edges();  // R10
    t_partial();      // R9
    t_empty_frame();  // R11
    t_byte_pair();    // R12
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule